// File: doc/BRIEF.md
# Serial Transmitter with Break and Parity-Error Injection

This block is the transmit half of an asynchronous serial port. A host writes a small register window to set the character format, the baud divisor and the queueing mode, and to load characters. The block frames each character with a start bit, the configured data bits sent least significant first, an optional parity bit and one or two stop bits. It drives the frame onto a single serial output, and it reports when its holding storage is empty.

Two line-test controls are built in. A break control holds the line low. The low level starts only at a bit boundary and ends on a baud tick. A parity-corruption control sends the wrong parity bit on purpose. The divisor bytes share two addresses with the data path. A latch bit in the line control register selects which of the two is reached. Characters wait either in a single holding register or in a 16-entry queue.

Top module: `serial_tx_brk`

## Requirements
- R1: After reset, txd is 1, thr_empty is 1, every line control bit and the queue-mode bit are 0, and the divisor is 0.
- R2: With line control bit 7 set, writes to address 0 load divisor bits [7:0] and writes to address 1 load divisor bits [15:8]. With it clear, address 0 takes a character and a write to address 1 changes nothing.
- R3: The baud generator gives one tick every divisor clocks, and a divisor of 0 gives no ticks at all. Every serial bit lasts 16 ticks.
- R4: A frame is one 0 start bit, then 5+N data bits sent least significant first (N = line control bits [1:0]), then the stop bits at 1. Line control bit 2 selects two stop bits instead of one.
- R5: With line control bit 3 set, a parity bit follows the data. Bit 4 = 1 selects even parity and bit 4 = 0 selects odd parity, counted over the configured data bits only.
- R6: With line control bits 5 and 3 both set, the parity bit is inverted. Bit 5 alone has no effect on the frame.
- R7: Line control bit 6 (break) drives txd to 0 from the next bit boundary. The bit in progress finishes first. The rest of the current frame is dropped, and the queue is emptied when the break begins.
- R8: After the break bit is cleared, txd returns to 1 on the next baud tick. A waiting character starts at a later bit boundary.
- R9: With address 2 bit 0 clear, one character is held. A write while it is occupied is dropped. thr_empty is 1 exactly when nothing is held.
- R10: With address 2 bit 0 set, up to 16 characters are queued and sent in order, and writes to a full queue are dropped. Any write to address 2 empties the queue.
- R11: When a character is waiting at the end of the last stop bit, its start bit follows with no idle time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| txd | output | 1 | Serial output, idle high |
| thr_empty | output | 1 | Holding register or queue is empty |

## Verification
The bench raises break in the middle of a data bit. A design that cuts the bit short, or that keeps the stale queue, shows a wrong txd or thr_empty on that cycle. It clears break between ticks. Here a design that recovers at once, or that waits for a full bit boundary, goes high on the wrong clock. The bench sends parity-corruption frames with parity enabled and with it disabled, runs 5-bit frames with parity and two stop bits, and fills both the holding register and the queue past capacity. An early or late parity, a dropped stop bit or an accepted overflow write each shows up against the model. A divisor of 0 and a write to the unused divisor-shadow address are also covered. The first must leave the line still. The second must not change the bit period.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam int DIV_W = 16;

  localparam logic [2:0] A_DATA  = 3'd0;
  localparam logic [2:0] A_SHDW  = 3'd1;
  localparam logic [2:0] A_QCTL  = 3'd2;
  localparam logic [2:0] A_LINE  = 3'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_BREAK
  } tx_state_e;

  typedef struct packed {
    logic       dla;    // divisor latch access
    logic       brk;    // force line low
    logic       fpe;    // invert parity bit
    logic       even;   // 1 even, 0 odd
    logic       pen;    // parity bit present
    logic       stop2;  // two stop bits
    logic [1:0] wlen;   // data bits minus five
  } line_ctl_t;

  // parity bit for the low 5+wlen bits of d
  function automatic logic par_bit(input logic [7:0] d, input logic [1:0] wlen,
                                   input logic even);
    logic x;
    x = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < 5 + int'(wlen)) x = x ^ d[i];
    return even ? x : ~x;
  endfunction
endpackage

// File: rtl/stx_baud.sv
module stx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (div != '0) && (cnt >= div - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt <= '0;
    else if (div == '0 || tick)    cnt <= '0;
    else                           cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/stx_queue.sv
module stx_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       deep,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  input  logic                       flush,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic [$clog2(DEPTH+1)-1:0] cap,
  output logic                       empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd, wr;
  logic          full, push_ok, pop_ok;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (int'(p) == DEPTH-1) ? '0 : p + PW'(1);
  endfunction

  assign cap     = deep ? CW'(DEPTH) : CW'(1);
  assign full    = count >= cap;
  assign empty   = count == '0;
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd <= '0; wr <= '0; count <= '0;
    end else begin
      if (push_ok) wr <= nxt(wr);
      if (pop_ok)  rd <= nxt(rd);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/stx_shift.sv
module stx_shift
  import stx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  line_ctl_t ctl,
  input  logic      q_empty,
  input  logic [7:0] q_head,
  output logic      pop,
  output logic      flush_req,
  output logic      boundary,
  output logic      recover,
  output logic      in_break,
  output logic      txd
);
  localparam int SUB_W = $clog2(OVERSAMPLE);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE-1);

  tx_state_e        state;
  logic [SUB_W-1:0] sub;
  logic [7:0]       sh;
  logic [2:0]       idx;
  logic             par;
  logic [2:0]       last_idx;
  logic             frame_end;

  assign boundary  = tick && (sub == SUB_LAST);
  assign recover   = (state == S_BREAK) && tick && !ctl.brk;
  assign in_break  = state == S_BREAK;
  assign flush_req = boundary && ctl.brk && (state != S_BREAK);
  assign last_idx  = 3'd4 + {1'b0, ctl.wlen};
  assign frame_end = (state == S_IDLE) || (state == S_STOP2) ||
                     ((state == S_STOP1) && !ctl.stop2);
  assign pop       = boundary && !ctl.brk && !q_empty && frame_end;

  always_ff @(posedge clk) begin
    if (!rst_n)                   sub <= '0;
    else if (recover)             sub <= '0;
    else if (tick)                sub <= (sub == SUB_LAST) ? '0 : sub + SUB_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; txd <= 1'b1; sh <= '0; idx <= '0; par <= 1'b0;
    end else if (recover) begin
      state <= S_IDLE; txd <= 1'b1;
    end else if (boundary) begin
      if (ctl.brk) begin
        state <= S_BREAK; txd <= 1'b0;
      end else begin
        unique case (state)
          S_START: begin
            txd <= sh[0]; sh <= sh >> 1; idx <= '0; state <= S_DATA;
          end
          S_DATA: begin
            if (idx == last_idx) begin
              if (ctl.pen) begin state <= S_PAR;   txd <= par ^ ctl.fpe; end
              else         begin state <= S_STOP1; txd <= 1'b1;          end
            end else begin
              idx <= idx + 3'd1; txd <= sh[0]; sh <= sh >> 1;
            end
          end
          S_PAR: begin state <= S_STOP1; txd <= 1'b1; end
          default: begin
            if (state == S_STOP1 && ctl.stop2) begin
              state <= S_STOP2; txd <= 1'b1;
            end else if (!q_empty) begin
              sh <= q_head; par <= par_bit(q_head, ctl.wlen, ctl.even);
              state <= S_START; txd <= 1'b0;
            end else begin
              state <= S_IDLE; txd <= 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_tx_brk.sv
module serial_tx_brk
  import stx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       thr_empty
);
  localparam int CW = $clog2(FIFO_DEPTH+1);

  line_ctl_t        line;
  logic             qmode;
  logic [DIV_W-1:0] div;

  logic             tick, boundary, recover, in_break;
  logic             pop, ser_flush, q_flush, q_push, q_empty;
  logic [7:0]       q_head;
  logic [CW-1:0]    q_count, q_cap;
  logic             qctl_wr;

  assign q_push  = wr_en && (wr_addr == A_DATA) && !line.dla;
  assign qctl_wr = wr_en && (wr_addr == A_QCTL);
  assign q_flush = ser_flush || qctl_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line <= '0; qmode <= 1'b0; div <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_DATA:  if (line.dla) div[7:0]  <= wr_data;
        A_SHDW:  if (line.dla) div[15:8] <= wr_data;
        A_QCTL:  qmode <= wr_data[0];
        A_LINE:  line  <= line_ctl_t'(wr_data);
        default: ;
      endcase
    end
  end

  stx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(div), .tick(tick)
  );

  stx_queue #(.W(8), .DEPTH(FIFO_DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .deep(qmode), .push(q_push), .push_data(wr_data),
    .pop(pop), .flush(q_flush), .head(q_head), .count(q_count), .cap(q_cap),
    .empty(q_empty)
  );

  stx_shift #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctl(line), .q_empty(q_empty),
    .q_head(q_head), .pop(pop), .flush_req(ser_flush), .boundary(boundary),
    .recover(recover), .in_break(in_break), .txd(txd)
  );

  assign thr_empty = q_empty;
endmodule

// File: rtl/stx_checker.sv
module stx_checker #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          txd,
  input logic          thr_empty,
  input logic          tick,
  input logic          boundary,
  input logic          recover,
  input logic          in_break,
  input logic          q_flush,
  input logic [15:0]   div,
  input logic [CW-1:0] q_count,
  input logic [CW-1:0] q_cap
);
  p_no_tick_div0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0) |-> !tick);

  p_txd_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (txd != $past(txd)) |-> $past(tick));

  p_break_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_break |-> !txd);

  p_break_at_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_break) |-> $past(boundary));

  p_recover_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> txd);

  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    q_flush |=> thr_empty);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= q_cap);
endmodule

bind serial_tx_brk stx_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .thr_empty(thr_empty), .tick(tick),
  .boundary(boundary), .recover(recover), .in_break(in_break),
  .q_flush(q_flush), .div(div), .q_count(q_count), .q_cap(q_cap)
);

// File: tb/tb_serial_tx_brk.sv
module tb_serial_tx_brk;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       txd, thr_empty;

  int checks = 0, errors = 0;
  int cur_div = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_tx_brk dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                     .wr_data(wr_data), .txd(txd), .thr_empty(thr_empty));

  // behavioural reference: 0 idle,1 start,2 data,3 parity,4 stop1,5 stop2,6 break
  int m_div, m_cnt, m_sub, m_st, m_txd, m_sh, m_idx, m_par, m_lcr, m_fifo;
  bit m_recov, m_b2b;
  byte unsigned q[$];

  function automatic int parity_ref(int d, int nb, int even);
    int ones = 0;
    for (int i = 0; i < nb; i++) ones += (d >> i) & 1;
    return even ? (ones % 2) : 1 - (ones % 2);
  endfunction

  task automatic start_next();
    if (q.size() > 0) begin
      m_b2b = (m_st == 4 || m_st == 5);
      m_sh = q.pop_front();
      m_par = parity_ref(m_sh, 5 + (m_lcr & 3), (m_lcr >> 4) & 1);
      m_st = 1; m_txd = 0;
    end else begin
      m_st = 0; m_txd = 1;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_sub = 0; m_st = 0; m_txd = 1; m_sh = 0; m_idx = 0;
      m_par = 0; m_lcr = 0; m_fifo = 0; m_recov = 0; m_b2b = 0; q.delete();
    end else begin
      bit tk, bnd, brk, full, flush;
      tk = (m_div != 0) && (m_cnt >= m_div - 1);
      bnd = tk && (m_sub == 15);
      brk = (m_lcr >> 6) & 1;
      full = q.size() >= (m_fifo ? 16 : 1);
      flush = 0;
      if (m_st == 6 && tk && !brk) begin
        m_st = 0; m_txd = 1; m_sub = 0; m_recov = 1;
      end else begin
        if (tk) m_sub = (m_sub + 1) % 16;
        if (bnd) begin
          m_recov = 0;
          if (brk) begin
            if (m_st != 6) flush = 1;
            m_st = 6; m_txd = 0;
          end else begin
            case (m_st)
              1: begin m_txd = m_sh & 1; m_sh >>= 1; m_idx = 0; m_st = 2; end
              2: if (m_idx == 4 + (m_lcr & 3)) begin
                   if ((m_lcr >> 3) & 1) begin m_st = 3; m_txd = m_par ^ ((m_lcr >> 5) & 1); end
                   else begin m_st = 4; m_txd = 1; end
                 end else begin
                   m_idx++; m_txd = m_sh & 1; m_sh >>= 1;
                 end
              3: begin m_st = 4; m_txd = 1; end
              4: if ((m_lcr >> 2) & 1) begin m_st = 5; m_txd = 1; end
                 else start_next();
              default: start_next();
            endcase
          end
        end
      end
      m_cnt = (m_div == 0 || tk) ? 0 : m_cnt + 1;
      if (flush) q.delete();
      if (wr_en) begin
        case (wr_addr)
          3'd0: if ((m_lcr >> 7) & 1) m_div = (m_div & 'hFF00) | wr_data;
                else if (!full && !flush) q.push_back(wr_data);
          3'd1: if ((m_lcr >> 7) & 1) m_div = (m_div & 'h00FF) | (int'(wr_data) << 8);
          3'd2: begin m_fifo = wr_data[0]; q.delete(); end
          3'd3: m_lcr = wr_data;
          default: ;
        endcase
      end
    end
  end

  function automatic string txd_tag();
    case (m_st)
      0: return m_recov ? "R8" : "R1";
      1: return m_b2b ? "R11" : "R4";
      3: return ((m_lcr >> 5) & 1) ? "R6" : "R5";
      6: return "R7";
      default: return "R4";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (txd !== m_txd[0]) begin
        errors++;
        $display("FAIL %s txd at %0t: actual=%0b expected=%0b", txd_tag(), $time, txd, m_txd[0]);
      end
      checks++;
      if (thr_empty !== (q.size() == 0)) begin
        errors++;
        $display("FAIL %s thr_empty at %0t: actual=%0b expected=%0b",
                 m_fifo ? "R10" : "R9", $time, thr_empty, q.size() == 0);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_div(input int d, input logic [7:0] line);
    wr(3'd3, 8'h80 | line);
    wr(3'd0, d[7:0]);
    wr(3'd1, d[15:8]);
    wr(3'd3, line);
    cur_div = d;
  endtask

  task automatic wait_idle();
    while (!thr_empty) @(negedge clk);
    repeat (16 * 14 * (cur_div == 0 ? 1 : cur_div)) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] line, input logic [7:0] d);
    wr(3'd3, line);
    wr(3'd0, d);
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lo;
    repeat (4) @(negedge clk);
    check("R1", txd, 1, "txd in reset");
    check("R1", thr_empty, 1, "thr_empty in reset");
    rst_n = 1'b1;
    // R3: divisor 0 gives no ticks, character stays queued
    wr(3'd0, 8'h3C);
    repeat (200) @(negedge clk);
    check("R3", txd, 1, "txd with divisor 0");
    check("R3", thr_empty, 0, "char held with divisor 0");
    wr(3'd2, 8'h00);
    // R2: divisor through latch bit, shadow address ignored without it
    set_div(3, 8'h03);
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'h55);
    while (txd) @(negedge clk);
    lo = 0;
    while (!txd) begin lo++; @(negedge clk); end
    check("R2", lo, 48, "start bit length after shadow write");
    check("R3", lo, 16 * 3, "start bit length is 16 ticks");
    wait_idle();
    set_div(1, 8'h03);
    send(8'h03, 8'hA6);           // R4 8N1
    send(8'h18, 8'hFD);           // R5 5-bit even parity
    send(8'h0E, 8'h4B);           // R4/R5 7-bit odd parity two stop
    send(8'h3B, 8'h81);           // R6 forced parity error
    send(8'h23, 8'h5A);           // R6 force without parity enable
    // R9 holding register overflow
    wr(3'd3, 8'h03);
    wr(3'd0, 8'h11); wr(3'd0, 8'h22); wr(3'd0, 8'h33);
    wait_idle();
    // R10 R11 queue mode, back-to-back frames and overflow
    wr(3'd2, 8'h01);
    for (int i = 0; i < 20; i++) wr(3'd0, 8'(i * 13 + 1));
    check("R10", thr_empty, 0, "queue filled");
    wait_idle();
    // R7 R8 break mid frame
    for (int i = 0; i < 4; i++) wr(3'd0, 8'(8'hC3 + i));
    repeat (37) @(negedge clk);
    wr(3'd3, 8'h43);
    repeat (300) @(negedge clk);
    check("R7", txd, 0, "txd during break");
    check("R7", thr_empty, 1, "queue flushed by break");
    wr(3'd0, 8'hA5);
    repeat (50) @(negedge clk);
    set_div(2, 8'h43);
    repeat (41) @(negedge clk);
    wr(3'd3, 8'h03);
    wait_idle();
    check("R8", txd, 1, "idle after recovery");
    // R10 queue-control write flushes
    for (int i = 0; i < 3; i++) wr(3'd0, 8'(8'h70 + i));
    wr(3'd2, 8'h01);
    check("R10", thr_empty, 1, "flush on queue control write");
    wait_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule